// File: doc/BRIEF.md
# Disk-to-Memory DMA Write Master

This block is the bus-side engine of a disk controller. Bytes coming off the disk arrive on a valid/ready stream and go into a small internal buffer. As soon as the buffer holds a byte and the bus is free, the block asks for the bus with a hold request. It then waits for the hold acknowledge. While it owns the bus, it writes each buffered byte into a 512-byte memory: it places a 9-bit address and an 8-bit data value on the bus and pulses an active-low write strobe for one bus clock. The memory latches the byte on the falling edge inside that clock.

When the buffer runs dry, the block gives the bus back. A full transfer is 512 bytes. When it completes, the block raises a done flag and releases the bus. It accepts no further input until the acknowledge has gone low. The write address keeps counting across bus tenures and wraps from 511 to 0, so a new transfer starts again at address 0.

The address and data pins are released through an output-enable signal. Whenever the block is not driving, the pins also read as zero, so a pad ring or shared-bus mux can tri-state them.

Top module: `dma_wr_master`

## Requirements
- R1: After reset, hold request is low, the write strobe is high, output enable and done are low, address and data read 0, and the input is ready.
- R2: Once a byte has been taken from the input while acknowledge is low, hold request goes high on the following clock edge.
- R3: The write strobe goes low only while hold request, acknowledge and output enable are all high. It stays low for exactly one clock, and there is at least one strobe-high clock between two writes.
- R4: Address and data change on the edge where the strobe falls. They keep their values through the next clock. Data values appear on the bus in the order the bytes were accepted.
- R5: The first write after reset goes to address 0. Each later write goes to the previous address plus one, wrapping from 511 to 0.
- R6: After a write, if the buffer is empty, hold request drops. Output enable is high only while acknowledge is high. Whenever output enable is low, address and data read 0.
- R7: After the 512th write of a transfer, done goes high and hold request goes low. Input ready stays low until acknowledge has been seen low. Done then clears and ready returns.
- R8: While acknowledge is still high after hold request has dropped, hold request is not raised again, even if a byte is buffered.
- R9: A byte is taken only on a clock edge where input valid and input ready are both high. Bytes sent while ready is high are all written, none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream byte valid |
| in_data | input | 8 | Upstream byte |
| in_ready | output | 1 | Block can take a byte |
| hold_req | output | 1 | Bus ownership request |
| hold_ack | input | 1 | Bus ownership grant |
| wr_n | output | 1 | Active-low write strobe |
| bus_oe | output | 1 | Address/data drive enable |
| bus_addr | output | 9 | Memory address |
| bus_data | output | 8 | Memory write data |
| xfer_done | output | 1 | Full transfer complete, waiting for bus release |

## Verification
The checker watches the strobe on every clock. It checks that the strobe lasts one cycle and is followed by a gap, and that it falls only under ownership. It also checks that address and data hold after the strobe, that each write address is one more than the last with wrap, that the pins are quiet and undriven without acknowledge, and that no new request starts while acknowledge lingers. The bench scenarios cover what no single-cycle property can see. They check that every accepted byte lands at its expected address in arrival order. They show the request dropping when the buffer empties under bursty input, and the done handshake with a slow bus release. They also show the address wrapping into the next transfer.

// File: rtl/dma_wr_pkg.sv
package dma_wr_pkg;

    localparam int unsigned BUS_AW = 9;
    localparam int unsigned BUS_DW = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WRITE,
        ST_GAP,
        ST_RELEASE
    } bus_state_e;

    typedef struct packed {
        bus_state_e          state;
        logic                hrq;
        logic                wr_n;
        logic                oe;
        logic [BUS_AW-1:0]   addr;
        logic [BUS_DW-1:0]   data;
        logic                done;
    } bus_regs_t;

endpackage

// File: rtl/dma_byte_fifo.sv
module dma_byte_fifo #(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_ptrs_t;

    fifo_ptrs_t ptr_d, ptr_q;
    logic [DW-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        ptr_d = ptr_q;
        if (push) ptr_d.wp = ptr_inc(ptr_q.wp);
        if (pop)  ptr_d.rp = ptr_inc(ptr_q.rp);
        if (push && !pop)      ptr_d.cnt = ptr_q.cnt + 1'b1;
        else if (pop && !push) ptr_d.cnt = ptr_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && ptr_q.wp == PW'(i)) mem_q[i] <= push_data;
        end
    end

    assign head  = mem_q[ptr_q.rp];
    assign empty = (ptr_q.cnt == '0);
    assign full  = (ptr_q.cnt == CW'(DEPTH));
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
    parameter int unsigned AW       = 9,
    parameter int unsigned XFER_LEN = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          clr_len,
    output logic [AW-1:0] next_addr,
    output logic          len_reached
);
    localparam int unsigned LW = $clog2(XFER_LEN + 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [LW-1:0] len;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d = gen_q;
        if (step) begin
            gen_d.addr = gen_q.addr + 1'b1;
            gen_d.len  = gen_q.len + 1'b1;
        end
        if (clr_len) gen_d.len = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign next_addr   = gen_q.addr;
    assign len_reached = (gen_q.len == LW'(XFER_LEN));
endmodule

// File: rtl/dma_bus_fsm.sv
module dma_bus_fsm
    import dma_wr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_empty,
    input  logic [BUS_DW-1:0] buf_head,
    input  logic [BUS_AW-1:0] next_addr,
    input  logic              len_reached,
    input  logic              hack,
    output logic              buf_pop,
    output logic              addr_step,
    output logic              len_clr,
    output bus_regs_t         regs
);
    bus_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        buf_pop   = 1'b0;
        addr_step = 1'b0;
        len_clr   = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (!buf_empty && !hack) begin
                    r_d.state = ST_REQ;
                    r_d.hrq   = 1'b1;
                end
            end
            ST_REQ: begin
                if (hack) begin
                    r_d.state = ST_WRITE;
                    r_d.wr_n  = 1'b0;
                    r_d.oe    = 1'b1;
                    r_d.addr  = next_addr;
                    r_d.data  = buf_head;
                    buf_pop   = 1'b1;
                    addr_step = 1'b1;
                end
            end
            ST_WRITE: begin
                r_d.state = ST_GAP;
                r_d.wr_n  = 1'b1;
            end
            ST_GAP: begin
                if (len_reached || buf_empty) begin
                    r_d.state = ST_RELEASE;
                    r_d.hrq   = 1'b0;
                    r_d.oe    = 1'b0;
                    r_d.addr  = '0;
                    r_d.data  = '0;
                    r_d.done  = len_reached;
                    len_clr   = len_reached;
                end else begin
                    r_d.state = ST_WRITE;
                    r_d.wr_n  = 1'b0;
                    r_d.addr  = next_addr;
                    r_d.data  = buf_head;
                    buf_pop   = 1'b1;
                    addr_step = 1'b1;
                end
            end
            ST_RELEASE: begin
                if (!hack) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b0;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.wr_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign regs = r_q;
endmodule

// File: rtl/dma_wr_master.sv
module dma_wr_master
    import dma_wr_pkg::*;
#(
    parameter int unsigned BUF_DEPTH = 4,
    parameter int unsigned XFER_LEN  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BUS_DW-1:0] in_data,
    output logic              in_ready,
    output logic              hold_req,
    input  logic              hold_ack,
    output logic              wr_n,
    output logic              bus_oe,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [BUS_DW-1:0] bus_data,
    output logic              xfer_done
);
    logic              buf_empty, buf_full, buf_pop, push;
    logic [BUS_DW-1:0] buf_head;
    logic [BUS_AW-1:0] next_addr;
    logic              len_reached, addr_step, len_clr;
    bus_regs_t         regs;

    assign in_ready = !buf_full && !regs.done;
    assign push     = in_valid && in_ready;

    dma_byte_fifo #(.DW(BUS_DW), .DEPTH(BUF_DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(in_data),
        .pop(buf_pop), .head(buf_head), .empty(buf_empty), .full(buf_full)
    );

    dma_addr_gen #(.AW(BUS_AW), .XFER_LEN(XFER_LEN)) u_addr (
        .clk(clk), .rst_n(rst_n), .step(addr_step), .clr_len(len_clr),
        .next_addr(next_addr), .len_reached(len_reached)
    );

    dma_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .buf_empty(buf_empty), .buf_head(buf_head),
        .next_addr(next_addr), .len_reached(len_reached), .hack(hold_ack),
        .buf_pop(buf_pop), .addr_step(addr_step), .len_clr(len_clr), .regs(regs)
    );

    assign hold_req  = regs.hrq;
    assign wr_n      = regs.wr_n;
    assign bus_oe    = regs.oe;
    assign bus_addr  = regs.addr;
    assign bus_data  = regs.data;
    assign xfer_done = regs.done;
endmodule

// File: rtl/dma_wr_master_chk.sv
module dma_wr_master_chk
    import dma_wr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              hold_req,
    input logic              hold_ack,
    input logic              wr_n,
    input logic              bus_oe,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [BUS_DW-1:0] bus_data,
    input logic              xfer_done
);
    logic              seen_q;
    logic [BUS_AW-1:0] last_q;

    p_strobe_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (hold_req && hold_ack && bus_oe));
    p_strobe_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> wr_n);
    p_bus_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> ($stable(bus_addr) && $stable(bus_data)));
    p_quiet_pins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_addr == '0 && bus_data == '0));
    p_drive_needs_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> hold_ack);
    p_done_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (!in_ready && !hold_req));
    p_no_rerequest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ack && !hold_req) |=> !hold_req);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (!wr_n && $fell(wr_n)) begin
            p_addr_step_r5: assert (seen_q ? (bus_addr == last_q + 1'b1) : (bus_addr == '0));
            seen_q <= 1'b1;
            last_q <= bus_addr;
        end
    end
endmodule

bind dma_wr_master dma_wr_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .hold_req(hold_req),
    .hold_ack(hold_ack), .wr_n(wr_n), .bus_oe(bus_oe), .bus_addr(bus_addr),
    .bus_data(bus_data), .xfer_done(xfer_done)
);

// File: tb/tb_dma_wr_master.sv
module tb_dma_wr_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready, hold_req, wr_n, bus_oe, xfer_done;
    logic       hold_ack;
    logic [8:0] bus_addr;
    logic [7:0] bus_data;

    always #10 clk = ~clk;

    dma_wr_master dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .hold_req(hold_req), .hold_ack(hold_ack),
        .wr_n(wr_n), .bus_oe(bus_oe), .bus_addr(bus_addr), .bus_data(bus_data),
        .xfer_done(xfer_done)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // bus owner model: grant/release after programmable delays
    int gnt_dly = 1;
    int rel_dly = 1;
    int hcnt;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_ack <= 1'b0;
            hcnt     <= 0;
        end else if (hold_req && !hold_ack) begin
            if (hcnt >= gnt_dly - 1) begin hold_ack <= 1'b1; hcnt <= 0; end
            else hcnt <= hcnt + 1;
        end else if (!hold_req && hold_ack) begin
            if (hcnt >= rel_dly - 1) begin hold_ack <= 1'b0; hcnt <= 0; end
            else hcnt <= hcnt + 1;
        end else begin
            hcnt <= 0;
        end
    end

    // scoreboard
    logic [16:0] exp_q[$];
    logic [8:0]  exp_addr = '0;
    int          n_sent = 0;

    task automatic send_byte(input logic [7:0] d);
        in_valid = 1'b1;
        in_data  = d;
        while (!in_ready) @(negedge clk);
        exp_q.push_back({exp_addr, d});
        exp_addr++;
        n_sent++;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: memory side latches on the falling edge
    logic       prev_low = 1'b0;
    logic [8:0] prev_addr;
    logic [7:0] prev_data;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_low) begin
                check(wr_n, "R3 strobe high after one cycle", wr_n, 1);
                check(bus_addr == prev_addr && bus_data == prev_data,
                      "R4 bus held after strobe", bus_addr, prev_addr);
            end
            if (!wr_n) begin
                check(hold_req && hold_ack && bus_oe, "R3 strobe under ownership",
                      {hold_req, hold_ack, bus_oe}, 7);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected write", bus_addr, -1);
                end else begin
                    logic [16:0] e;
                    e = exp_q.pop_front();
                    check(bus_addr == e[16:8], "R5 write address", bus_addr, e[16:8]);
                    check(bus_data == e[7:0], "R4 write data order", bus_data, e[7:0]);
                end
            end
            if (!hold_ack)
                check(!bus_oe && bus_addr == 0 && bus_data == 0, "R6 pins quiet without ack",
                      {bus_oe, bus_addr}, 0);
            prev_low  = !wr_n;
            prev_addr = bus_addr;
            prev_data = bus_data;
        end
    end

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !hold_req && !hold_ack && !xfer_done) break;
        end
        check(exp_q.size() == 0, "R9 all bytes written", exp_q.size(), 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!hold_req && wr_n && !bus_oe && !xfer_done, "R1 reset controls",
              {hold_req, wr_n, bus_oe, xfer_done}, 4);
        check(bus_addr == 0 && bus_data == 0 && in_ready, "R1 reset bus/ready", bus_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // single byte: request timing and release on empty buffer
        send_byte(8'hA5);
        check(!hold_req, "R2 request not before buffer sees byte", hold_req, 0);
        @(negedge clk);
        check(hold_req, "R2 request one edge after byte", hold_req, 1);
        wait_idle();

        // back-to-back burst with slow grant
        gnt_dly = 3;
        for (int i = 0; i < 10; i++) send_byte(8'(i * 37 + 5));
        wait_idle();

        // bursty input: buffer empties, request drops and returns
        gnt_dly = 1;
        rel_dly = 6;
        for (int i = 0; i < 4; i++) begin
            send_byte(8'(8'hC0 + i));
            repeat (8) @(negedge clk);
        end
        wait_idle();

        // R8: byte arrives while ack lingers after release
        send_byte(8'h3C);
        for (int i = 0; i < 50; i++) begin
            if (!hold_req && hold_ack && exp_q.size() == 0) break;
            @(negedge clk);
        end
        check(hold_ack && !hold_req, "R6 request dropped on empty buffer",
              {hold_ack, hold_req}, 2);
        send_byte(8'h99);
        check(in_ready, "R9 byte taken during release", in_ready, 1);
        while (hold_ack) begin
            check(!hold_req, "R8 no request while ack high", hold_req, 0);
            @(negedge clk);
        end
        wait_idle();

        // complete the transfer to reach done
        rel_dly = 4;
        while (n_sent < 512) send_byte(8'(n_sent ^ 8'h5A));
        for (int i = 0; i < 100; i++) begin
            if (xfer_done) break;
            @(negedge clk);
        end
        check(xfer_done, "R7 done after 512 writes", xfer_done, 1);
        check(!hold_req && !in_ready && hold_ack, "R7 request off, input blocked",
              {hold_req, in_ready, hold_ack}, 1);
        for (int i = 0; i < 20; i++) begin
            if (!xfer_done) break;
            @(negedge clk);
        end
        check(!hold_ack, "R7 done held until ack low", hold_ack, 0);
        check(in_ready && !xfer_done, "R7 ready returns after release", in_ready, 1);

        // second transfer wraps to address 0
        for (int i = 0; i < 3; i++) send_byte(8'(8'hE0 + i));
        wait_idle();
        check(exp_addr == 9'd3, "R5 wrap bookkeeping", exp_addr, 3);
        summary();
    end
endmodule